// File: doc/BRIEF.md
# Segment reload validation sequencer

When a task switch has committed, the incoming task's seven segment selectors must be qualified before their descriptor caches are filled. This block receives the selectors as one vector, ordered LDT, CS, SS, DS, ES, FS and GS. It visits them in that order. For each selector that is not null, it requests the descriptor through a fetch port and waits for an acknowledge. The acknowledge carries either the decoded descriptor fields or a fetch-failure flag.

The rules differ by register class and are relative to privilege. The CS selector's RPL acts as the reference privilege for SS and the data registers. The first violation ends the walk. The block then reports a fault class and an error code. If every selector passes, the block pulses a per-register load strobe, one bit for each selector whose descriptor was fetched and accepted.

Top module: `seg_reload_checker`

## Requirements
- R1: Non-null selectors are fetched strictly in slot order (0 LDT, 1 CS, 2 SS, 3 DS, 4 ES, 5 FS, 6 GS). Null selectors are skipped without a fetch. `fetch_sel` equals the selector and stays stable while `fetch_req` waits for `fetch_ack`.
- R2: A selector is null when bits 15:2 are zero. A null LDT or data selector is accepted and its strobe bit stays 0. A null CS or SS is an invalid-TSS fault. On success the CS and SS strobe bits are always 1.
- R3: `fault_kind` encodes 1 = invalid-TSS, 2 = not-present, 3 = stack fault. `fault_code` is the offending selector ANDed with 0xFFFC.
- R4: An LDT selector with bit 2 set faults invalid-TSS without a fetch. An LDT descriptor must have code/data flag 0, type 2 and limit ≥ 7, else invalid-TSS. If it is absent, the fault is also invalid-TSS.
- R5: CS needs code/data flag 1 and type bit 3. If type bit 2 = 0 (non-conforming), DPL must equal the selector RPL. If type bit 2 = 1 (conforming), DPL must be ≤ RPL. Violations are invalid-TSS. Only after these checks does an absent CS give not-present.
- R6: SS needs code/data flag 1, type bit 3 = 0 and type bit 1 = 1, else invalid-TSS. Next, an absent SS gives a stack fault. After that, DPL must equal the CS RPL and the SS RPL, else invalid-TSS.
- R7: A data register needs code/data flag 1 and must not have type bit 3 = 1 with type bit 1 = 0, else invalid-TSS. When type < 12, DPL must be ≥ the CS RPL and ≥ its own RPL, else invalid-TSS. Then an absent descriptor gives not-present.
- R8: When `fetch_fail` is set on an acknowledge, the fault is invalid-TSS for that selector, whatever the descriptor fields hold.
- R9: After the first fault no further fetch is issued, and `done_fault` pulses for one cycle.
- R10: `busy` is high from the cycle after `start` until the completion pulse. Exactly one of `done_ok` and `done_fault` pulses for one cycle. `load_strobe` is nonzero only together with `done_ok`.
- R11: `start` while busy is ignored, including any change to `sel_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a validation walk (sampled when idle) |
| sel_in | input | 16*NSLOT | Selectors, slot 0 in the low 16 bits |
| fetch_req | output | 1 | Descriptor request pending |
| fetch_sel | output | 16 | Selector to fetch |
| fetch_ack | input | 1 | Fetch response valid |
| fetch_fail | input | 1 | Fetch could not complete |
| desc_code_data | input | 1 | Descriptor is code/data (1) or system (0) |
| desc_type | input | 4 | Descriptor type field |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_present | input | 1 | Descriptor present flag |
| desc_limit | input | 20 | Descriptor limit |
| busy | output | 1 | Walk in progress |
| done_ok | output | 1 | One-cycle success pulse |
| done_fault | output | 1 | One-cycle fault pulse |
| fault_kind | output | 2 | Fault class, held until next start |
| fault_code | output | 16 | Error code, held until next start |
| load_strobe | output | NSLOT | Per-slot cache-load strobe with done_ok |

## Verification
Two of the block's functions can meet in one cycle. The first is a new `start` request. The second is an acknowledge that is still being judged, or a walk that has not yet reached its completion pulse. The bench provokes this by raising `start` with inverted selectors one cycle into a long, fully valid walk. It then judges the outcome by comparing the fetched selectors, the strobe vector and the completion against the prediction for the original selectors. Within a single descriptor, several violations can also coincide. Directed cases stack them, for example an absent SS with wrong privilege, or a conforming CS with excess DPL that is also absent, to confirm the stated check priority.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    localparam int SELW = 16;
    localparam int LIMW = 20;

    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_TSS   = 2'd1,
        FK_NP    = 2'd2,
        FK_STACK = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        SC_LDT,
        SC_CODE,
        SC_STACK,
        SC_DATA
    } seg_class_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_WAIT
    } seq_state_e;

    typedef struct packed {
        logic            code_data;
        logic [3:0]      kind;
        logic [1:0]      dpl;
        logic            present;
        logic [LIMW-1:0] limit;
    } desc_t;

    // Slot position decides the checking class.
    function automatic seg_class_e class_of(input int slot);
        case (slot)
            0:       return SC_LDT;
            1:       return SC_CODE;
            2:       return SC_STACK;
            default: return SC_DATA;
        endcase
    endfunction

    function automatic logic sel_null(input logic [SELW-1:0] s);
        return (s[SELW-1:2] == '0);
    endfunction

    // Faults decided from the selector alone, before any fetch.
    function automatic fault_e pre_fault(input seg_class_e c, input logic [SELW-1:0] s);
        if (c == SC_LDT && s[2])
            return FK_TSS;
        if (sel_null(s) && (c == SC_CODE || c == SC_STACK))
            return FK_TSS;
        return FK_NONE;
    endfunction

    // Descriptor qualification, ordered by priority inside each class.
    function automatic fault_e desc_fault(input seg_class_e c, input logic [SELW-1:0] s,
                                          input logic [1:0] cs_rpl, input desc_t d);
        logic [1:0] rpl;
        rpl = s[1:0];
        case (c)
            SC_LDT: begin
                if (d.code_data || d.kind != 4'd2 || d.limit < 20'd7) return FK_TSS;
                if (!d.present) return FK_TSS;
            end
            SC_CODE: begin
                if (!d.code_data || !d.kind[3]) return FK_TSS;
                if (!d.kind[2] && d.dpl != rpl) return FK_TSS;
                if (d.kind[2] && d.dpl > rpl) return FK_TSS;
                if (!d.present) return FK_NP;
            end
            SC_STACK: begin
                if (!d.code_data || d.kind[3] || !d.kind[1]) return FK_TSS;
                if (!d.present) return FK_STACK;
                if (d.dpl != cs_rpl) return FK_TSS;
                if (d.dpl != rpl) return FK_TSS;
            end
            default: begin
                if (!d.code_data || (d.kind[3] && !d.kind[1])) return FK_TSS;
                if (d.kind < 4'd12 && (d.dpl < cs_rpl || d.dpl < rpl)) return FK_TSS;
                if (!d.present) return FK_NP;
            end
        endcase
        return FK_NONE;
    endfunction

endpackage

// File: rtl/seg_desc_judge.sv
module seg_desc_judge
    import seg_chk_pkg::*;
(
    input  seg_class_e       cls,
    input  logic [SELW-1:0]  sel,
    input  logic [1:0]       cs_rpl,
    input  logic             fetch_fail,
    input  desc_t            desc,
    output fault_e           verdict
);
    always_comb begin
        if (fetch_fail)
            verdict = FK_TSS;
        else
            verdict = desc_fault(cls, sel, cs_rpl, desc);
    end
endmodule

// File: rtl/seg_seq_ctrl.sv
module seg_seq_ctrl
    import seg_chk_pkg::*;
#(
    parameter int NSLOT = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [NSLOT-1:0][SELW-1:0]  sels,
    input  logic                        fetch_ack,
    input  fault_e                      verdict,
    output logic                        fetch_req,
    output logic [SELW-1:0]             fetch_sel,
    output seg_class_e                  cur_class,
    output logic [1:0]                  cs_rpl,
    output logic                        busy,
    output logic                        done_ok,
    output logic                        done_fault,
    output fault_e                      fault_kind,
    output logic [SELW-1:0]             fault_code,
    output logic [NSLOT-1:0]            load_strobe
);
    localparam int IW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam logic [IW-1:0] LAST = IW'(NSLOT - 1);

    seq_state_e                  st_q;
    logic [NSLOT-1:0][SELW-1:0]  sel_q;
    logic [IW-1:0]               idx_q;
    logic [NSLOT-1:0]            loaded_q;
    logic                        ok_q, flt_q;
    fault_e                      kind_q;
    logic [SELW-1:0]             code_q;

    logic [SELW-1:0] cur_sel;
    fault_e          pre;
    logic            last;

    assign cur_sel   = sel_q[idx_q];
    assign cur_class = class_of(int'(idx_q));
    assign pre       = pre_fault(cur_class, cur_sel);
    assign last      = (idx_q == LAST);
    assign cs_rpl    = sel_q[1][1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            sel_q    <= '0;
            idx_q    <= '0;
            loaded_q <= '0;
            ok_q     <= 1'b0;
            flt_q    <= 1'b0;
            kind_q   <= FK_NONE;
            code_q   <= '0;
        end else begin
            ok_q  <= 1'b0;
            flt_q <= 1'b0;
            case (st_q)
                ST_IDLE: if (start) begin
                    sel_q    <= sels;
                    idx_q    <= '0;
                    loaded_q <= '0;
                    kind_q   <= FK_NONE;
                    code_q   <= '0;
                    st_q     <= ST_SCAN;
                end
                ST_SCAN: begin
                    if (pre != FK_NONE) begin
                        kind_q <= pre;
                        code_q <= cur_sel & 16'hFFFC;
                        flt_q  <= 1'b1;
                        st_q   <= ST_IDLE;
                    end else if (sel_null(cur_sel)) begin
                        if (last) begin
                            ok_q <= 1'b1;
                            st_q <= ST_IDLE;
                        end else begin
                            idx_q <= idx_q + IW'(1);
                        end
                    end else begin
                        st_q <= ST_WAIT;
                    end
                end
                ST_WAIT: if (fetch_ack) begin
                    if (verdict != FK_NONE) begin
                        kind_q <= verdict;
                        code_q <= cur_sel & 16'hFFFC;
                        flt_q  <= 1'b1;
                        st_q   <= ST_IDLE;
                    end else begin
                        loaded_q[idx_q] <= 1'b1;
                        if (last) begin
                            ok_q <= 1'b1;
                            st_q <= ST_IDLE;
                        end else begin
                            idx_q <= idx_q + IW'(1);
                            st_q  <= ST_SCAN;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign fetch_req   = (st_q == ST_WAIT);
    assign fetch_sel   = cur_sel;
    assign busy        = (st_q != ST_IDLE);
    assign done_ok     = ok_q;
    assign done_fault  = flt_q;
    assign fault_kind  = kind_q;
    assign fault_code  = code_q;
    assign load_strobe = ok_q ? loaded_q : '0;

    p_one_done_r10: assert property (@(posedge clk) disable iff (rst)
        !(done_ok && done_fault));
    p_ok_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done_ok |=> !done_ok);
    p_fault_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_fault |=> !done_fault && !fetch_req);
    p_req_hold_r1: assert property (@(posedge clk) disable iff (rst)
        fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_sel));
    p_code_mask_r3: assert property (@(posedge clk) disable iff (rst)
        done_fault |-> fault_code[1:0] == 2'b00 && fault_kind != FK_NONE);
    p_cs_ss_loaded_r2: assert property (@(posedge clk) disable iff (rst)
        done_ok |-> load_strobe[1] && load_strobe[2]);
    p_start_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> $stable(sel_q));
endmodule

// File: rtl/seg_reload_checker.sv
module seg_reload_checker
    import seg_chk_pkg::*;
#(
    parameter int NUM_DATA = 4,
    localparam int NSLOT   = 3 + NUM_DATA
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [NSLOT*16-1:0]   sel_in,
    output logic                  fetch_req,
    output logic [15:0]           fetch_sel,
    input  logic                  fetch_ack,
    input  logic                  fetch_fail,
    input  logic                  desc_code_data,
    input  logic [3:0]            desc_type,
    input  logic [1:0]            desc_dpl,
    input  logic                  desc_present,
    input  logic [19:0]           desc_limit,
    output logic                  busy,
    output logic                  done_ok,
    output logic                  done_fault,
    output logic [1:0]            fault_kind,
    output logic [15:0]           fault_code,
    output logic [NSLOT-1:0]      load_strobe
);
    logic [NSLOT-1:0][SELW-1:0] sels;
    desc_t      desc;
    seg_class_e cls;
    logic [1:0] cs_rpl;
    fault_e     verdict;
    fault_e     kind;

    for (genvar g = 0; g < NSLOT; g++) begin : g_unpack
        assign sels[g] = sel_in[g*SELW +: SELW];
    end

    assign desc = '{code_data: desc_code_data, kind: desc_type, dpl: desc_dpl,
                    present: desc_present, limit: desc_limit};

    seg_desc_judge u_judge (
        .cls        (cls),
        .sel        (fetch_sel),
        .cs_rpl     (cs_rpl),
        .fetch_fail (fetch_fail),
        .desc       (desc),
        .verdict    (verdict)
    );

    seg_seq_ctrl #(.NSLOT(NSLOT)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .sels        (sels),
        .fetch_ack   (fetch_ack),
        .verdict     (verdict),
        .fetch_req   (fetch_req),
        .fetch_sel   (fetch_sel),
        .cur_class   (cls),
        .cs_rpl      (cs_rpl),
        .busy        (busy),
        .done_ok     (done_ok),
        .done_fault  (done_fault),
        .fault_kind  (kind),
        .fault_code  (fault_code),
        .load_strobe (load_strobe)
    );

    assign fault_kind = kind;

    p_fetch_fail_r8: assert property (@(posedge clk) disable iff (rst)
        fetch_req && fetch_ack && fetch_fail |=> done_fault && fault_kind == 2'd1);
endmodule

// File: tb/seg_reload_checker_test.sv
module seg_reload_checker_test;

    typedef struct {
        bit        cd;
        bit [3:0]  ty;
        bit [1:0]  dpl;
        bit        p;
        bit [19:0] lim;
        bit        fail;
    } bdesc_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [111:0] sel_in = '0;
    logic        fetch_req;
    logic [15:0] fetch_sel;
    logic        fetch_ack = 1'b0;
    logic        fetch_fail = 1'b0;
    logic        desc_code_data = 1'b0;
    logic [3:0]  desc_type = '0;
    logic [1:0]  desc_dpl = '0;
    logic        desc_present = 1'b0;
    logic [19:0] desc_limit = '0;
    logic        busy, done_ok, done_fault;
    logic [1:0]  fault_kind;
    logic [15:0] fault_code;
    logic [6:0]  load_strobe;

    int n_checks = 0;
    int n_fails  = 0;

    bit [15:0] tsel [7];
    bdesc_t    tdesc [7];
    int        exp_kind;
    bit [15:0] exp_code;
    bit [6:0]  exp_strobe;
    int        exp_slot [7];
    int        exp_nfetch;

    seg_reload_checker uut (
        .clk(clk), .rst(rst), .start(start), .sel_in(sel_in),
        .fetch_req(fetch_req), .fetch_sel(fetch_sel), .fetch_ack(fetch_ack),
        .fetch_fail(fetch_fail), .desc_code_data(desc_code_data),
        .desc_type(desc_type), .desc_dpl(desc_dpl), .desc_present(desc_present),
        .desc_limit(desc_limit), .busy(busy), .done_ok(done_ok),
        .done_fault(done_fault), .fault_kind(fault_kind), .fault_code(fault_code),
        .load_strobe(load_strobe)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Bench reading of the rules: 0 ok, 1 invalid-TSS, 2 not-present, 3 stack.
    function automatic int bjudge(int s, bit [15:0] sl, bit [1:0] csr, bdesc_t d);
        bit [1:0] r = sl[1:0];
        if (d.fail) return 1;
        if (s == 0) begin
            if (d.cd || d.ty != 4'd2 || d.lim < 20'd7) return 1;
            if (!d.p) return 1;
            return 0;
        end
        if (s == 1) begin
            if (!d.cd || !d.ty[3]) return 1;
            if (!d.ty[2] && d.dpl != r) return 1;
            if (d.ty[2] && d.dpl > r) return 1;
            if (!d.p) return 2;
            return 0;
        end
        if (s == 2) begin
            if (!d.cd || d.ty[3] || !d.ty[1]) return 1;
            if (!d.p) return 3;
            if (d.dpl != csr || d.dpl != r) return 1;
            return 0;
        end
        if (!d.cd || (d.ty[3] && !d.ty[1])) return 1;
        if (d.ty < 4'd12 && (d.dpl < csr || d.dpl < r)) return 1;
        if (!d.p) return 2;
        return 0;
    endfunction

    task automatic compute_expect();
        bit [1:0] csr = tsel[1][1:0];
        exp_kind = 0; exp_code = 0; exp_strobe = 0; exp_nfetch = 0;
        for (int s = 0; s < 7; s++) begin
            int k;
            bit nul = (tsel[s][15:2] == 14'd0);
            if (s == 0 && tsel[s][2]) begin
                exp_kind = 1; exp_code = tsel[s] & 16'hFFFC; break;
            end
            if (nul) begin
                if (s == 1 || s == 2) begin
                    exp_kind = 1; exp_code = tsel[s] & 16'hFFFC; break;
                end
                continue;
            end
            exp_slot[exp_nfetch] = s;
            exp_nfetch++;
            k = bjudge(s, tsel[s], csr, tdesc[s]);
            if (k != 0) begin
                exp_kind = k; exp_code = tsel[s] & 16'hFFFC; break;
            end
            exp_strobe[s] = 1'b1;
        end
    endtask

    // Deterministic all-valid baseline with CS privilege csr.
    task automatic set_good(input bit [1:0] csr);
        tsel[0] = {13'h0021, 1'b0, 2'b00};
        tsel[1] = {13'h0002, 1'b0, csr};
        tsel[2] = {13'h0003, 1'b0, csr};
        for (int s = 3; s < 7; s++) tsel[s] = {13'(16 + s), 1'b1, csr};
        tdesc[0] = '{cd: 0, ty: 4'd2, dpl: 0, p: 1, lim: 20'h0003F, fail: 0};
        tdesc[1] = '{cd: 1, ty: 4'b1010, dpl: csr, p: 1, lim: 20'hFFFFF, fail: 0};
        tdesc[2] = '{cd: 1, ty: 4'b0010, dpl: csr, p: 1, lim: 20'hFFFFF, fail: 0};
        for (int s = 3; s < 7; s++)
            tdesc[s] = '{cd: 1, ty: 4'b0011, dpl: 2'd3, p: 1, lim: 20'hFFFFF, fail: 0};
    endtask

    task automatic randomize_case(input int mut);
        bit [1:0] csr = 2'($urandom_range(0, 3));
        set_good(csr);
        for (int s = 0; s < 7; s++) begin
            bit [12:0] ix = 13'($urandom_range(1, 8191));
            bit [1:0]  rp = (s == 1 || s == 2) ? csr : 2'($urandom_range(0, 3));
            bit        ti = (s == 0) ? 1'b0 : 1'($urandom_range(0, 1));
            tsel[s] = {ix, ti, rp};
            if ($urandom_range(0, (s == 1 || s == 2) ? 19 : 6) == 0)
                tsel[s] = {14'd0, 2'($urandom_range(0, 3))};
            if (s == 1 && $urandom_range(0, 1) == 1) begin
                tdesc[1].ty  = 4'b1110;
                tdesc[1].dpl = 2'($urandom_range(0, csr));
            end
            if (s >= 3) begin
                tdesc[s].ty = 4'($urandom_range(0, 15));
                if (tdesc[s].ty[3]) tdesc[s].ty[1] = 1'b1;
                if (tdesc[s].ty < 4'd12)
                    tdesc[s].dpl = 2'($urandom_range((csr > rp) ? csr : rp, 3));
                else
                    tdesc[s].dpl = 2'($urandom_range(0, 3));
            end
            if (s == 0) tdesc[0].lim = 20'($urandom_range(7, 4095));
            if ($urandom_range(0, mut) == 0) begin
                case ($urandom_range(0, 6))
                    0: tdesc[s].p    = 1'b0;
                    1: tdesc[s].fail = 1'b1;
                    2: tdesc[s].ty   = 4'($urandom_range(0, 15));
                    3: tdesc[s].cd   = ~tdesc[s].cd;
                    4: tdesc[s].dpl  = 2'($urandom_range(0, 3));
                    5: tdesc[s].lim  = 20'($urandom_range(0, 9));
                    default: if (s == 0) tsel[0][2] = 1'b1;
                endcase
            end
        end
    endtask

    task automatic run_case(input string tag, input bit poke_start);
        int  nf = 0;
        int  cyc = 0;
        bit  fin = 0;
        compute_expect();
        @(negedge clk);
        for (int s = 0; s < 7; s++) sel_in[s*16 +: 16] = tsel[s];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10", "busy after start", busy, 1);
        while (!fin && cyc < 400) begin
            start = 1'b0;
            if (poke_start && cyc == 1) begin
                sel_in = ~sel_in;
                start  = 1'b1;
            end
            if (done_ok || done_fault) begin
                check("R10", "single completion", done_ok && done_fault, 0);
                check(tag, "outcome is fault", done_fault, exp_kind != 0);
                check("R1,R9", "fetch count", nf, exp_nfetch);
                if (exp_kind != 0) begin
                    check({tag, ",R3"}, "fault kind", fault_kind, exp_kind);
                    check({tag, ",R3"}, "fault code", fault_code, exp_code);
                end else begin
                    check({tag, ",R2,R10"}, "load strobes", load_strobe, exp_strobe);
                end
                @(negedge clk);
                start = 1'b0;
                check("R10", "pulse ends", done_ok || done_fault, 0);
                check("R10", "idle after done", busy, 0);
                fin = 1;
            end else if (fetch_req) begin
                int lat = $urandom_range(0, 2);
                if (nf >= exp_nfetch) begin
                    check("R9", "unexpected extra fetch", fetch_sel, 16'hFFFF);
                    fin = 1;
                end else begin
                    int s = exp_slot[nf];
                    check("R1", "fetch selector order", fetch_sel, tsel[s]);
                    for (int w = 0; w < lat; w++) begin
                        @(negedge clk);
                        start = 1'b0;
                        cyc++;
                        check("R1", "request held", fetch_req, 1);
                    end
                    fetch_ack      = 1'b1;
                    fetch_fail     = tdesc[s].fail;
                    desc_code_data = tdesc[s].fail ? 1'($urandom) : tdesc[s].cd;
                    desc_type      = tdesc[s].fail ? 4'($urandom) : tdesc[s].ty;
                    desc_dpl       = tdesc[s].dpl;
                    desc_present   = tdesc[s].fail ? 1'($urandom) : tdesc[s].p;
                    desc_limit     = tdesc[s].lim;
                    @(negedge clk);
                    start      = 1'b0;
                    fetch_ack  = 1'b0;
                    fetch_fail = 1'b0;
                    nf++;
                    cyc++;
                end
            end else begin
                @(negedge clk);
                cyc++;
            end
        end
        start = 1'b0;
        if (!fin) check(tag, "case completion", 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        process::self().srandom(32'd20250);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10", "reset busy", busy, 0);
        check("R10", "reset done", done_ok || done_fault, 0);
        check("R1", "reset request", fetch_req, 0);

        // R2: data selectors null, only CS and SS loaded
        set_good(2'd0);
        for (int s = 3; s < 7; s++) tsel[s] = 16'h0003;
        tsel[0] = 16'h0000;
        run_case("R2", 0);
        // R2: null CS with nonzero RPL
        set_good(2'd3); tsel[1] = 16'h0003; run_case("R2", 0);
        // R2: null SS
        set_good(2'd1); tsel[2] = 16'h0001; run_case("R2", 0);
        // R4: table-indicator bit in LDT selector
        set_good(2'd0); tsel[0] = 16'h0124; run_case("R4", 0);
        // R4: absent LDT gives invalid-TSS
        set_good(2'd0); tdesc[0].p = 0; run_case("R4", 0);
        // R4: short LDT limit
        set_good(2'd0); tdesc[0].lim = 20'd6; run_case("R4", 0);
        // R5: absent CS
        set_good(2'd2); tdesc[1].p = 0; run_case("R5", 0);
        // R5: conforming CS with excess DPL outranks absence
        set_good(2'd1); tdesc[1].ty = 4'b1110; tdesc[1].dpl = 2'd2; tdesc[1].p = 0; run_case("R5", 0);
        // R5: conforming CS with lower DPL passes
        set_good(2'd3); tdesc[1].ty = 4'b1110; tdesc[1].dpl = 2'd0; run_case("R5", 0);
        // R6: absent SS with wrong DPL gives stack fault
        set_good(2'd2); tdesc[2].p = 0; tdesc[2].dpl = 2'd0; run_case("R6", 0);
        // R6: SS DPL mismatch
        set_good(2'd2); tdesc[2].dpl = 2'd1; run_case("R6", 0);
        // R6: read-only stack
        set_good(2'd0); tdesc[2].ty = 4'b0000; run_case("R6", 0);
        // R7: execute-only code in ES
        set_good(2'd0); tdesc[4].ty = 4'b1000; run_case("R7", 0);
        // R7: data DPL below CS RPL
        set_good(2'd2); tdesc[3].dpl = 2'd1; run_case("R7", 0);
        // R7: conforming readable code with low DPL passes
        set_good(2'd3); tdesc[5].ty = 4'b1110; tdesc[5].dpl = 2'd0; run_case("R7", 0);
        // R7: absent FS
        set_good(2'd0); tdesc[5].p = 0; run_case("R7", 0);
        // R8: fetch failure on GS
        set_good(2'd1); tdesc[6].fail = 1; run_case("R8", 0);
        // R9: early failure stops later fetches
        set_good(2'd0); tdesc[1].fail = 1; run_case("R9", 0);
        // R11: start pulse during a busy walk
        set_good(2'd0); run_case("R11", 1);

        for (int n = 0; n < 400; n++) begin
            randomize_case(8);
            run_case("R4,R5,R6,R7,R8", (n % 17) == 3);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule